// File: doc/BRIEF.md
# Serial Byte FIFO Pair With Watermark Requests

This block sits between a serial transmitter/receiver pair and the host side of a serial port. It holds two independent byte queues. The transmit queue is filled by the host and drained by the transmit shifter. The receive queue is filled by the receive shifter and drained by the host. Each queue reports how many words it holds and whether it is empty. It keeps sticky error flags for rejected operations and can be emptied in a single cycle.

Each direction compares its occupancy with a programmable watermark. The receive side raises a sticky ready flag once enough words have arrived. The transmit side raises one once the queue has drained far enough. Each ready flag, when its request enable is set, is routed to an interrupt line or to a DMA request line by a per-direction select bit. A per-direction enable switches the queue between its full depth and a single-word legacy buffer. The fixed depth of each queue is reported as a 3-bit code.

Top module: `sfifo_wm_pair`

## Requirements
- R1: Each depth code output is a constant derived from the depth parameter. The encoding is 000 for 1 word, 001 for 4, 010 for 8, 011 for 16, 100 for 32, 101 for 64 and 110 for 128 words; 111 is never produced. The default 8-word transmit queue reports 010, and the default 16-word receive queue reports 011.
- R2: Each queue is first-in first-out. The read data output shows the oldest stored word whenever the count is non-zero. A push and a pop accepted in the same cycle leave the count unchanged, and each accepted push or pop changes the count by one at the next clock edge.
- R3: While a direction's FIFO enable is 0, that queue holds at most one word. A push while it already holds one or more words is rejected.
- R4: A push into a full queue (count at or above its capacity) is dropped and sets that direction's sticky overflow flag at the next edge. The flag stays set until its clear input is pulsed in a cycle with no new overflow.
- R5: A receive pop from an empty queue is dropped and sets the sticky receive underflow flag, with the same clear rule as R4. A transmit pop from an empty queue is ignored and records nothing.
- R6: A flush pulse empties its queue by the next edge (count 0, empty 1). Any push or pop in the same cycle is ignored and records no error, and the sticky error and ready flags keep their values.
- R7: The receive ready flag sets at the edge after a cycle in which the receive count is greater than or equal to the receive watermark. Its clear input takes effect only in a cycle in which that condition is false.
- R8: The transmit ready flag sets at the edge after a cycle in which the transmit count is less than or equal to the transmit watermark, with the same clear rule as R7.
- R9: For each direction, the interrupt output is ready AND request-enable AND NOT dma-select, and the DMA output is ready AND request-enable AND dma-select. The two are never high together.
- R10: The error interrupt is the OR of each sticky error flag (receive underflow, transmit overflow, receive overflow) ANDed with its own enable.
- R11: Each empty output is 1 exactly when that direction's count is 0.
- R12: While reset is low, both counts are 0, both empty outputs are 1, and all sticky flags and request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_fifo_en_i | input | 1 | Transmit full-depth enable (0 = single word) |
| tx_water_i | input | WATER_W | Transmit watermark |
| tx_wr_i | input | 1 | Host push into transmit queue |
| tx_wdata_i | input | DATA_W | Host transmit data |
| tx_take_i | input | 1 | Shifter pop from transmit queue |
| tx_flush_i | input | 1 | Transmit flush pulse |
| tx_req_en_i | input | 1 | Transmit request enable |
| tx_dma_sel_i | input | 1 | Transmit request to DMA (1) or interrupt (0) |
| tx_of_ie_i | input | 1 | Transmit overflow interrupt enable |
| tx_of_clr_i | input | 1 | Clear transmit overflow flag |
| tx_ready_clr_i | input | 1 | Clear transmit ready flag |
| tx_rdata_o | output | DATA_W | Oldest transmit word |
| tx_count_o | output | TX_DEPTH_LOG2+1 | Transmit occupancy |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_of_o | output | 1 | Sticky transmit overflow |
| tx_ready_o | output | 1 | Sticky transmit ready flag |
| tx_irq_o | output | 1 | Transmit interrupt request |
| tx_dma_o | output | 1 | Transmit DMA request |
| tx_depth_code_o | output | 3 | Transmit depth code |
| rx_fifo_en_i | input | 1 | Receive full-depth enable (0 = single word) |
| rx_water_i | input | WATER_W | Receive watermark |
| rx_put_i | input | 1 | Shifter push into receive queue |
| rx_wdata_i | input | DATA_W | Received data |
| rx_rd_i | input | 1 | Host pop from receive queue |
| rx_flush_i | input | 1 | Receive flush pulse |
| rx_req_en_i | input | 1 | Receive request enable |
| rx_dma_sel_i | input | 1 | Receive request to DMA (1) or interrupt (0) |
| rx_of_ie_i | input | 1 | Receive overflow interrupt enable |
| rx_uf_ie_i | input | 1 | Receive underflow interrupt enable |
| rx_of_clr_i | input | 1 | Clear receive overflow flag |
| rx_uf_clr_i | input | 1 | Clear receive underflow flag |
| rx_ready_clr_i | input | 1 | Clear receive ready flag |
| rx_rdata_o | output | DATA_W | Oldest receive word |
| rx_count_o | output | RX_DEPTH_LOG2+1 | Receive occupancy |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_of_o | output | 1 | Sticky receive overflow |
| rx_uf_o | output | 1 | Sticky receive underflow |
| rx_ready_o | output | 1 | Sticky receive ready flag |
| rx_irq_o | output | 1 | Receive interrupt request |
| rx_dma_o | output | 1 | Receive DMA request |
| rx_depth_code_o | output | 3 | Receive depth code |
| err_irq_o | output | 1 | Combined error interrupt |

## Verification
The queues are driven with push-heavy traffic that keeps them pinned at full, so overflow rejection can be told apart from a silently wrapping pointer. Pop-heavy traffic separates the receive underflow flag from the transmit side's silent ignore. Runs with the FIFO enable cleared show whether capacity truly collapses to one word, and runs that toggle it check the switch between the two capacities. Frequent flushes mixed with pushes, pops and flag clears show that flush wins over same-cycle operations and leaves the sticky flags intact. Watermarks swept from zero to beyond the depth, together with random select and clear bits, separate the >= and <= comparisons, the set-over-clear priority and the interrupt/DMA steering.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned MIN_LOG2 = 2;
  localparam int unsigned MAX_LOG2 = 7;

  // 1 word -> 0, 2^k words (k>=2) -> k-1
  function automatic logic [2:0] depth_code(input int unsigned log2_depth);
    if (log2_depth == 0) return 3'd0;
    return 3'(log2_depth - 1);
  endfunction
endpackage

// File: rtl/sfifo_core.sv
module sfifo_core #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DEPTH_LOG2 = 4,
  parameter int unsigned WATER_W    = 8,
  parameter bit          READY_GE   = 1'b1,
  parameter bit          TRACK_UF   = 1'b1,
  localparam int unsigned DEPTH     = 1 << DEPTH_LOG2,
  localparam int unsigned CNT_W     = DEPTH_LOG2 + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_fifo_i,
  input  logic [WATER_W-1:0] water_i,
  input  logic               push_i,
  input  logic [DATA_W-1:0]  pdata_i,
  input  logic               pop_i,
  input  logic               flush_i,
  input  logic               clr_of_i,
  input  logic               clr_uf_i,
  input  logic               clr_ready_i,
  output logic [DATA_W-1:0]  data_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               empty_o,
  output logic               of_o,
  output logic               uf_o,
  output logic               ready_o
);
  logic [DATA_W-1:0]     mem_q [DEPTH];
  logic [DEPTH_LOG2-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]      count_q, cap;
  logic [WATER_W-1:0]    cnt_ext;
  logic full, empty, do_push, do_pop, push_rej, pop_rej;
  logic of_q, ready_q, ready_cond;

  assign cap      = en_fifo_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full     = (count_q >= cap);
  assign empty    = (count_q == '0);
  assign do_push  = push_i & ~full  & ~flush_i;
  assign do_pop   = pop_i  & ~empty & ~flush_i;
  assign push_rej = push_i &  full  & ~flush_i;
  assign pop_rej  = pop_i  &  empty & ~flush_i;
  assign cnt_ext  = WATER_W'(count_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) of_q <= 1'b0;
    else         of_q <= push_rej | (of_q & ~clr_of_i);
  end

  generate
    if (READY_GE) begin : g_ready_ge
      assign ready_cond = (cnt_ext >= water_i);
    end else begin : g_ready_le
      assign ready_cond = (cnt_ext <= water_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= ready_cond | (ready_q & ~clr_ready_i);
  end

  generate
    if (TRACK_UF) begin : g_uf
      logic uf_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) uf_q <= 1'b0;
        else         uf_q <= pop_rej | (uf_q & ~clr_uf_i);
      end
      assign uf_o = uf_q;

      // R5: pop from empty is recorded
      a_r5_uf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pop_i && count_q == '0 && !flush_i) |=> uf_o);
    end else begin : g_no_uf
      logic unused_uf;
      assign unused_uf = clr_uf_i ^ pop_rej;
      assign uf_o = 1'b0;
    end
  endgenerate

  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign empty_o = empty;
  assign of_o    = of_q;
  assign ready_o = ready_q;

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r4_of_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && count_q >= cap && !pop_i && !flush_i) |=> ($stable(count_q) && of_o));
  a_r3_single_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_fifo_i && count_q != '0 && push_i && !pop_i && !flush_i) |=> $stable(count_q));
  a_r6_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0 && empty_o));
  a_r6_flush_keeps_of: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !clr_of_i) |=> (of_o == $past(of_o)));
  a_r7_ready_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_cond |=> ready_o);
endmodule

// File: rtl/sfifo_req_route.sv
module sfifo_req_route (
  input  logic ready_i,
  input  logic req_en_i,
  input  logic dma_sel_i,
  output logic irq_o,
  output logic dma_o
);
  logic req;
  assign req   = ready_i & req_en_i;
  assign irq_o = req & ~dma_sel_i;
  assign dma_o = req &  dma_sel_i;
endmodule

// File: rtl/sfifo_wm_pair.sv
module sfifo_wm_pair
  import sfifo_pkg::*;
#(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned TX_DEPTH_LOG2 = 3,
  parameter int unsigned RX_DEPTH_LOG2 = 4,
  parameter int unsigned WATER_W       = 8,
  localparam int unsigned TX_CNT_W     = TX_DEPTH_LOG2 + 1,
  localparam int unsigned RX_CNT_W     = RX_DEPTH_LOG2 + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_fifo_en_i,
  input  logic [WATER_W-1:0]  tx_water_i,
  input  logic                tx_wr_i,
  input  logic [DATA_W-1:0]   tx_wdata_i,
  input  logic                tx_take_i,
  input  logic                tx_flush_i,
  input  logic                tx_req_en_i,
  input  logic                tx_dma_sel_i,
  input  logic                tx_of_ie_i,
  input  logic                tx_of_clr_i,
  input  logic                tx_ready_clr_i,
  output logic [DATA_W-1:0]   tx_rdata_o,
  output logic [TX_CNT_W-1:0] tx_count_o,
  output logic                tx_empty_o,
  output logic                tx_of_o,
  output logic                tx_ready_o,
  output logic                tx_irq_o,
  output logic                tx_dma_o,
  output logic [2:0]          tx_depth_code_o,
  input  logic                rx_fifo_en_i,
  input  logic [WATER_W-1:0]  rx_water_i,
  input  logic                rx_put_i,
  input  logic [DATA_W-1:0]   rx_wdata_i,
  input  logic                rx_rd_i,
  input  logic                rx_flush_i,
  input  logic                rx_req_en_i,
  input  logic                rx_dma_sel_i,
  input  logic                rx_of_ie_i,
  input  logic                rx_uf_ie_i,
  input  logic                rx_of_clr_i,
  input  logic                rx_uf_clr_i,
  input  logic                rx_ready_clr_i,
  output logic [DATA_W-1:0]   rx_rdata_o,
  output logic [RX_CNT_W-1:0] rx_count_o,
  output logic                rx_empty_o,
  output logic                rx_of_o,
  output logic                rx_uf_o,
  output logic                rx_ready_o,
  output logic                rx_irq_o,
  output logic                rx_dma_o,
  output logic [2:0]          rx_depth_code_o,
  output logic                err_irq_o
);
  logic unused_tx_uf;
  logic [1:0] ready_v, en_v, sel_v, irq_v, dma_v;

  sfifo_core #(
    .DATA_W(DATA_W), .DEPTH_LOG2(TX_DEPTH_LOG2), .WATER_W(WATER_W),
    .READY_GE(1'b0), .TRACK_UF(1'b0)
  ) u_tx (
    .clk_i, .rst_ni,
    .en_fifo_i(tx_fifo_en_i), .water_i(tx_water_i),
    .push_i(tx_wr_i), .pdata_i(tx_wdata_i), .pop_i(tx_take_i),
    .flush_i(tx_flush_i), .clr_of_i(tx_of_clr_i), .clr_uf_i(1'b0),
    .clr_ready_i(tx_ready_clr_i),
    .data_o(tx_rdata_o), .count_o(tx_count_o), .empty_o(tx_empty_o),
    .of_o(tx_of_o), .uf_o(unused_tx_uf), .ready_o(tx_ready_o)
  );

  sfifo_core #(
    .DATA_W(DATA_W), .DEPTH_LOG2(RX_DEPTH_LOG2), .WATER_W(WATER_W),
    .READY_GE(1'b1), .TRACK_UF(1'b1)
  ) u_rx (
    .clk_i, .rst_ni,
    .en_fifo_i(rx_fifo_en_i), .water_i(rx_water_i),
    .push_i(rx_put_i), .pdata_i(rx_wdata_i), .pop_i(rx_rd_i),
    .flush_i(rx_flush_i), .clr_of_i(rx_of_clr_i), .clr_uf_i(rx_uf_clr_i),
    .clr_ready_i(rx_ready_clr_i),
    .data_o(rx_rdata_o), .count_o(rx_count_o), .empty_o(rx_empty_o),
    .of_o(rx_of_o), .uf_o(rx_uf_o), .ready_o(rx_ready_o)
  );

  // index 0 = transmit, 1 = receive
  assign ready_v = {rx_ready_o, tx_ready_o};
  assign en_v    = {rx_req_en_i, tx_req_en_i};
  assign sel_v   = {rx_dma_sel_i, tx_dma_sel_i};

  for (genvar i = 0; i < 2; i++) begin : g_route
    sfifo_req_route u_route (
      .ready_i(ready_v[i]), .req_en_i(en_v[i]), .dma_sel_i(sel_v[i]),
      .irq_o(irq_v[i]), .dma_o(dma_v[i])
    );
  end

  assign tx_irq_o = irq_v[0];
  assign tx_dma_o = dma_v[0];
  assign rx_irq_o = irq_v[1];
  assign rx_dma_o = dma_v[1];

  assign err_irq_o = (rx_uf_o & rx_uf_ie_i) | (tx_of_o & tx_of_ie_i) | (rx_of_o & rx_of_ie_i);

  assign tx_depth_code_o = depth_code(TX_DEPTH_LOG2);
  assign rx_depth_code_o = depth_code(RX_DEPTH_LOG2);

  initial begin
    a_r1_depth_range: assert (TX_DEPTH_LOG2 >= MIN_LOG2 && TX_DEPTH_LOG2 <= MAX_LOG2 &&
                              RX_DEPTH_LOG2 >= MIN_LOG2 && RX_DEPTH_LOG2 <= MAX_LOG2);
  end

  a_r9_tx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_irq_o && tx_dma_o));
  a_r9_rx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_irq_o && rx_dma_o));
  a_r8_tx_ready_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WATER_W'(tx_count_o) <= tx_water_i) |=> tx_ready_o);
  a_r5_tx_pop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_take_i && tx_empty_o && !tx_wr_i) |=> tx_empty_o);
endmodule

// File: tb/tb_sfifo_wm_pair.sv
`timescale 1ns/1ps
module tb_sfifo_wm_pair;
  localparam int TXL = 3, RXL = 4;
  localparam int TXD = 1 << TXL, RXD = 1 << RXL;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic tx_en, tx_wr, tx_take, tx_flush, tx_req_en, tx_sel, tx_of_ie, tx_of_clr, tx_rdy_clr;
  logic [7:0] tx_water, tx_wdata;
  logic rx_en, rx_put, rx_rd, rx_flush, rx_req_en, rx_sel, rx_of_ie, rx_uf_ie;
  logic rx_of_clr, rx_uf_clr, rx_rdy_clr;
  logic [7:0] rx_water, rx_wdata;

  logic [7:0] tx_rdata, rx_rdata;
  logic [TXL:0] tx_count;
  logic [RXL:0] rx_count;
  logic tx_empty, tx_of, tx_ready, tx_irq, tx_dma;
  logic rx_empty, rx_of, rx_uf, rx_ready, rx_irq, rx_dma, err_irq;
  logic [2:0] tx_code, rx_code;

  sfifo_wm_pair dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_fifo_en_i(tx_en), .tx_water_i(tx_water), .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata),
    .tx_take_i(tx_take), .tx_flush_i(tx_flush), .tx_req_en_i(tx_req_en),
    .tx_dma_sel_i(tx_sel), .tx_of_ie_i(tx_of_ie), .tx_of_clr_i(tx_of_clr),
    .tx_ready_clr_i(tx_rdy_clr),
    .tx_rdata_o(tx_rdata), .tx_count_o(tx_count), .tx_empty_o(tx_empty), .tx_of_o(tx_of),
    .tx_ready_o(tx_ready), .tx_irq_o(tx_irq), .tx_dma_o(tx_dma), .tx_depth_code_o(tx_code),
    .rx_fifo_en_i(rx_en), .rx_water_i(rx_water), .rx_put_i(rx_put), .rx_wdata_i(rx_wdata),
    .rx_rd_i(rx_rd), .rx_flush_i(rx_flush), .rx_req_en_i(rx_req_en),
    .rx_dma_sel_i(rx_sel), .rx_of_ie_i(rx_of_ie), .rx_uf_ie_i(rx_uf_ie),
    .rx_of_clr_i(rx_of_clr), .rx_uf_clr_i(rx_uf_clr), .rx_ready_clr_i(rx_rdy_clr),
    .rx_rdata_o(rx_rdata), .rx_count_o(rx_count), .rx_empty_o(rx_empty), .rx_of_o(rx_of),
    .rx_uf_o(rx_uf), .rx_ready_o(rx_ready), .rx_irq_o(rx_irq), .rx_dma_o(rx_dma),
    .rx_depth_code_o(rx_code), .err_irq_o(err_irq)
  );

  // reference model
  logic [7:0] txq[$], rxq[$];
  bit m_tx_of, m_rx_of, m_rx_uf, m_tx_rdy, m_rx_rdy;
  bit m_tx_flushed, m_rx_flushed;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_tx_of = 0; m_rx_of = 0; m_rx_uf = 0; m_tx_rdy = 0; m_rx_rdy = 0;
      m_tx_flushed = 0; m_rx_flushed = 0;
    end else begin
      int tcap, rcap;
      bit tfull, tempty, rfull, rempty;
      tcap = tx_en ? TXD : 1;
      rcap = rx_en ? RXD : 1;
      tfull = txq.size() >= tcap; tempty = txq.size() == 0;
      rfull = rxq.size() >= rcap; rempty = rxq.size() == 0;
      m_tx_rdy = (txq.size() <= int'(tx_water)) || (m_tx_rdy && !tx_rdy_clr);
      m_rx_rdy = (rxq.size() >= int'(rx_water)) || (m_rx_rdy && !rx_rdy_clr);
      m_tx_of = (tx_wr && tfull && !tx_flush) || (m_tx_of && !tx_of_clr);
      m_rx_of = (rx_put && rfull && !rx_flush) || (m_rx_of && !rx_of_clr);
      m_rx_uf = (rx_rd && rempty && !rx_flush) || (m_rx_uf && !rx_uf_clr);
      m_tx_flushed = tx_flush; m_rx_flushed = rx_flush;
      if (tx_flush) txq.delete();
      else begin
        if (tx_take && !tempty) void'(txq.pop_front());
        if (tx_wr && !tfull) txq.push_back(tx_wdata);
      end
      if (rx_flush) rxq.delete();
      else begin
        if (rx_rd && !rempty) void'(rxq.pop_front());
        if (rx_put && !rfull) rxq.push_back(rx_wdata);
      end
    end
  end

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ti, td, ri, rd;
    ti = m_tx_rdy && tx_req_en && !tx_sel; td = m_tx_rdy && tx_req_en && tx_sel;
    ri = m_rx_rdy && rx_req_en && !rx_sel; rd = m_rx_rdy && rx_req_en && rx_sel;
    chk("R1", "tx depth code", 32'(tx_code), 32'd2);
    chk("R1", "rx depth code", 32'(rx_code), 32'd3);
    chk(tx_en ? "R2" : "R3", "tx count", 32'(tx_count), 32'(txq.size()));
    chk(rx_en ? "R2" : "R3", "rx count", 32'(rx_count), 32'(rxq.size()));
    if (txq.size() > 0) chk("R2", "tx data", 32'(tx_rdata), 32'(txq[0]));
    if (rxq.size() > 0) chk("R2", "rx data", 32'(rx_rdata), 32'(rxq[0]));
    if (m_tx_flushed) chk("R6", "tx count after flush", 32'(tx_count), 32'd0);
    if (m_rx_flushed) chk("R6", "rx count after flush", 32'(rx_count), 32'd0);
    chk("R11", "tx empty", 32'(tx_empty), 32'(txq.size() == 0));
    chk("R11", "rx empty", 32'(rx_empty), 32'(rxq.size() == 0));
    chk("R4", "tx overflow", 32'(tx_of), 32'(m_tx_of));
    chk("R4", "rx overflow", 32'(rx_of), 32'(m_rx_of));
    chk("R5", "rx underflow", 32'(rx_uf), 32'(m_rx_uf));
    chk("R7", "rx ready", 32'(rx_ready), 32'(m_rx_rdy));
    chk("R8", "tx ready", 32'(tx_ready), 32'(m_tx_rdy));
    chk("R9", "tx irq/dma", {30'd0, tx_irq, tx_dma}, {30'd0, ti, td});
    chk("R9", "rx irq/dma", {30'd0, rx_irq, rx_dma}, {30'd0, ri, rd});
    chk("R10", "err irq", 32'(err_irq),
        32'((m_rx_uf && rx_uf_ie) || (m_tx_of && tx_of_ie) || (m_rx_of && rx_of_ie)));
  endtask

  function automatic bit pct(input int p);
    return $urandom_range(99) < p;
  endfunction

  task automatic drive(input int p_push, input int p_pop, input int p_flush, input int p_clr);
    tx_wr = pct(p_push); tx_take = pct(p_pop); tx_wdata = 8'($urandom);
    rx_put = pct(p_push); rx_rd = pct(p_pop); rx_wdata = 8'($urandom);
    tx_flush = pct(p_flush); rx_flush = pct(p_flush);
    tx_of_clr = pct(p_clr); rx_of_clr = pct(p_clr); rx_uf_clr = pct(p_clr);
    tx_rdy_clr = pct(p_clr * 3); rx_rdy_clr = pct(p_clr * 3);
    tx_req_en = pct(80); rx_req_en = pct(80);
    tx_sel = pct(50); rx_sel = pct(50);
    tx_of_ie = pct(60); rx_of_ie = pct(60); rx_uf_ie = pct(60);
  endtask

  initial begin
    tx_en = 1; rx_en = 1; tx_water = 8'd2; rx_water = 8'd4;
    drive(0, 0, 0, 0);
    tx_wr = 0; tx_take = 0; rx_put = 0; rx_rd = 0; tx_flush = 0; rx_flush = 0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12", "tx count in reset", 32'(tx_count), 32'd0);
    chk("R12", "rx count in reset", 32'(rx_count), 32'd0);
    chk("R12", "empties in reset", {30'd0, tx_empty, rx_empty}, 32'd3);
    chk("R12", "flags in reset",
        {25'd0, tx_of, rx_of, rx_uf, tx_ready, rx_ready, err_irq, tx_irq | rx_irq | tx_dma | rx_dma},
        32'd0);
    rst_n = 1'b1;
    for (int ph = 0; ph < 6; ph++) begin
      for (int c = 0; c < 600; c++) begin
        @(negedge clk);
        compare_all();
        if (c % 64 == 0) begin
          tx_water = 8'($urandom_range(TXD + 2));
          rx_water = 8'($urandom_range(RXD + 2));
        end
        case (ph)
          0: begin tx_en = 1; rx_en = 1; drive(65, 25, 0, 3); end   // fill, overflow
          1: begin drive(20, 70, 0, 3); end                         // drain, underflow
          2: begin tx_en = 0; rx_en = 0; drive(50, 45, 0, 5); end   // single-word mode
          3: begin tx_en = 1; rx_en = 1; drive(60, 35, 8, 5); end   // flush mix
          4: begin drive(50, 50, 2, 20); end                        // clears, steering
          default: begin
            if (c % 40 == 0) begin tx_en = pct(50); rx_en = pct(50); end
            drive(55, 45, 3, 8);
          end
        endcase
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule